// File: doc/BRIEF.md
# Per-Pin Input Deglitcher

This block conditions the inputs of a general-purpose pin port. Pin levels may move at any moment relative to the clock, so every pin first passes through a chain of synchronizer flops. After that, each pin has its own small state machine and counter. When filtering is turned off for a pin, its synchronized level goes straight to the output register. When filtering is turned on, a new level reaches the output only after it has been sampled unchanged on a fixed number of consecutive clock edges. Anything shorter is removed completely. The conditioned word feeds both the input-data readback and the edge/level interrupt detector.

A configuration word with one bit per pin selects filtered or unfiltered behaviour for each pin on its own. Each per-pin machine has three states:
- `ST_PASS`: filtering is off, and the output register copies the synchronized level on every edge.
- `ST_IDLE`: filtering is on, and the synchronized level equals the output.
- `ST_SETTLE`: filtering is on, and the synchronized level differs from the output while its run length is counted.

The transitions are as follows:
- Any state goes to `ST_PASS` when the enable bit is low. The output register loads the synchronized level.
- `ST_PASS` goes to `ST_IDLE` when the enable bit is high.
- `ST_IDLE` goes to `ST_SETTLE` when the synchronized level differs from the output. The count is loaded with 1.
- `ST_SETTLE` goes back to `ST_IDLE` in two cases. If the level returns to the output value (a glitch), the count is dropped. If the count has reached `FILTER_CYCLES`-1 and the level is still different (a commit), the output takes the new level.
- Otherwise `ST_SETTLE` stays and increments the count.

`FILTER_CYCLES` must be at least 2.

Top module: `pin_filter_bank`

## Requirements
- R1: While reset is asserted, all outputs and synchronizer flops are 0, and every pin machine is in `ST_PASS`.
- R2: For a pin whose enable bit is 0, a level change at the pin appears at its output 3 rising edges later (2 synchronizer stages plus the output register). Pulses of any width, including 1 cycle, are reproduced with their width unchanged.
- R3: For a pin whose enable bit is 1, a level change that is held appears at its output `FILTER_CYCLES`+2 rising edges after the pin changes.
- R4: For a pin whose enable bit is 1, a pulse of either polarity held for 1 to `FILTER_CYCLES`-1 sampling edges never reaches the output.
- R5: For a pin whose enable bit is 1, a pulse of either polarity held for `FILTER_CYCLES` or more edges appears at the output with exactly its original width.
- R6: Every pin is filtered independently. Activity on one pin never changes another pin's output, and each pin follows only its own bit of the enable word (bit i controls pin i).
- R7: Clearing a pin's enable bit while that pin is settling abandons the count. The output then loads the synchronized level on the next edge. Setting the bit again does not disturb an output that already matches the input.
- R8: The run counter of a pin never exceeds `FILTER_CYCLES`-1. While enabled, the output changes only on a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| filt_en_i | input | NUM_PINS | Per-pin filter enable, bit i for pin i |
| pin_i | input | NUM_PINS | Raw pin levels, asynchronous to the clock |
| pin_o | output | NUM_PINS | Conditioned pin levels |

## Verification
The bench builds the block with `NUM_PINS`=4 and `FILTER_CYCLES`=4. This makes it practical to sweep every pin, every pulse width from 1 to `FILTER_CYCLES`+2, and both pulse polarities, under four enable patterns: all off, all on, and the two alternating patterns. Because the filter length is short, the bench can cover the full window around the threshold, from the longest suppressed pulse to the shortest pulse that passes. For each case, the expected output width and first-change latency are computed arithmetically from the pulse width and the enable bit. The quiet pins are checked for zero activity.

// File: rtl/pnf_pkg.sv
package pnf_pkg;

    // Per-pin conditioning state
    typedef enum logic [1:0] {
        ST_PASS   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SETTLE = 2'd2
    } flt_state_e;

endpackage

// File: rtl/pnf_sync.sv
module pnf_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pnf_filter.sv
module pnf_filter
    import pnf_pkg::*;
#(
    parameter int FILTER_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic sync_i,
    output logic out_o
);

    localparam int CW   = (FILTER_CYCLES > 2) ? $clog2(FILTER_CYCLES) : 1;
    localparam int LAST = FILTER_CYCLES - 1;

    flt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          out_q, out_d;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
        end
    end

    // Next state, count and output
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        unique case (state_q)
            ST_PASS: begin
                out_d = sync_i;
                cnt_d = '0;
                if (en_i) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (!en_i) begin
                    state_d = ST_PASS;
                    out_d   = sync_i;
                end else if (sync_i != out_q) begin
                    state_d = ST_SETTLE;
                    cnt_d   = CW'(1);
                end
            end
            ST_SETTLE: begin
                if (!en_i) begin
                    state_d = ST_PASS;
                    out_d   = sync_i;
                    cnt_d   = '0;
                end else if (sync_i == out_q) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(LAST)) begin
                    state_d = ST_IDLE;
                    out_d   = sync_i;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                state_d = ST_PASS;
                cnt_d   = '0;
            end
        endcase
    end

    assign out_o = out_q;

    // R8
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CW'(LAST));

    // R8
    commit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(out_q) && $past(en_i) && $past(state_q) != ST_PASS)
            |-> $past(cnt_q) == CW'(LAST));

    // R2
    bypass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!en_i) |-> out_q == $past(sync_i));

    // R4
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state_q == ST_IDLE && sync_i == out_q) |=> $stable(out_q));

endmodule

// File: rtl/pin_filter_bank.sv
module pin_filter_bank #(
    parameter int NUM_PINS      = 32,
    parameter int FILTER_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] filt_en_i,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] pin_o
);

    logic [NUM_PINS-1:0] sync_w;

    pnf_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .q_o    (sync_w)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pnf_filter #(
            .FILTER_CYCLES (FILTER_CYCLES)
        ) u_flt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (filt_en_i[g]),
            .sync_i (sync_w[g]),
            .out_o  (pin_o[g])
        );
    end

    // R1
    reset_low_chk: assert property (@(posedge clk_i)
        !rst_ni |-> pin_o == '0);

endmodule

// File: tb/sim_pin_filter_bank.sv
module sim_pin_filter_bank;

    localparam int NP = 4;
    localparam int FC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] en = '0;
    logic [NP-1:0] pins = '0;
    logic [NP-1:0] outw;

    int checks = 0;
    int errors = 0;
    int dev_cnt [NP];
    int first_k;

    always #5 clk = ~clk;

    pin_filter_bank #(
        .NUM_PINS      (NP),
        .FILTER_CYCLES (FC),
        .SYNC_STAGES   (2)
    ) u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .filt_en_i (en),
        .pin_i     (pins),
        .pin_o     (outw)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse of width len on pin p against steady level base
    task automatic run_pulse(input int p, input logic base, input int len,
                             input logic [NP-1:0] enw);
        int total;
        en   = enw;
        pins = {NP{base}};
        repeat (FC + 6) @(negedge clk);
        chk("R6 settle", int'(outw), int'({NP{base}}));
        for (int q = 0; q < NP; q++) dev_cnt[q] = 0;
        first_k = 0;
        pins[p] = ~base;
        total = len + FC + 8;
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            for (int q = 0; q < NP; q++)
                if (outw[q] != base) dev_cnt[q]++;
            if (outw[p] != base && first_k == 0) first_k = k;
            if (k == len) pins[p] = base;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset out", int'(outw), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(outw), 0);

        foreach (en[i]) en[i] = 1'b0;
        for (int b = 0; b < 2; b++) begin
            for (int e = 0; e < 4; e++) begin
                logic [NP-1:0] enw;
                case (e)
                    0: enw = '0;
                    1: enw = '1;
                    2: enw = 4'b0101;
                    default: enw = 4'b1010;
                endcase
                for (int p = 0; p < NP; p++) begin
                    for (int len = 1; len <= FC + 2; len++) begin
                        int  expw;
                        int  expk;
                        string tg;
                        run_pulse(p, logic'(b), len, enw);
                        if (!enw[p]) begin
                            expw = len; expk = 3; tg = "R2 width";
                        end else if (len < FC) begin
                            expw = 0; expk = 0; tg = "R4 suppressed";
                        end else begin
                            expw = len; expk = FC + 2; tg = "R5 width";
                        end
                        chk(tg, dev_cnt[p], expw);
                        chk(enw[p] ? "R3 latency" : "R2 latency", first_k, expk);
                        for (int q = 0; q < NP; q++)
                            if (q != p) chk("R6 quiet pin", dev_cnt[q], 0);
                    end
                end
            end
        end

        // R7: disable during settling, then re-enable
        en   = '1;
        pins = '0;
        repeat (FC + 6) @(negedge clk);
        pins[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 still settling", int'(outw[0]), 0);
        en[0] = 1'b0;
        @(negedge clk);
        chk("R7 pass after disable", int'(outw[0]), 1);
        en[0] = 1'b1;
        for (int k = 0; k < FC + 4; k++) begin
            @(negedge clk);
            chk("R7 steady after enable", int'(outw[0]), 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule